// File: doc/BRIEF.md
# Programmer Host Command Interpreter

This block sits between a host byte stream (typically fed by a UART receiver) and a byte-wide serial programming engine. It takes single-letter command bytes, collects any argument bytes that follow them, and keeps two pieces of state: a 16-bit target address and the code of the selected target device. Each memory command becomes one or more four-byte serial programming instructions. These are handed one byte at a time to an external SPI byte engine over a request/acknowledge handshake. Reply bytes go out on a transmit byte stream with a valid/ready handshake. A reply is data, a carriage return (0x0D) or an error mark ('?', 0x3F).

Post-write delays are not timed here. After a write the block raises a wait request, with a flag that picks a short or long wait. It then holds until an external timer reports done. Commands are processed strictly one at a time: no new host byte is taken while a command still has instructions, waits or replies pending.

Top module: `prog_cmd_interp`

## Requirements
- R1: After reset, rx_ready is high and tx_valid, spi_req and wait_req are low. The address is 0x0000 and the device code is 0x00, so gated commands are refused until 'T' selects a supported device.
- R2: An ESC byte (0x1B) received while waiting for a command is dropped with no reply, and the next byte is decoded as a command.
- R3: 'T' takes one argument and stores it as the device code. 'A' takes two arguments, high byte first, and loads the address. Each replies 0x0D.
- R4: 'T', 'S', 'V', 'v', 'p', 't', 'x' and 'y' work with any device code. Any other letter is answered with one '?' when the device code is not one of 0x12, 0x13, 0x20, 0x28, 0x38, 0x48, 0x40, 0x41; its arguments are then not consumed. An unknown letter is always answered with '?'.
- R5: 't' returns 0x12, 0x13, 0x20, 0x28, 0x38, 0x48, 0x00. 'V' returns 0x30+SW_MAJOR then 0x30+SW_MINOR, and 'v' does the same with the hardware numbers. 'p' returns 'P' (0x50). 'S' returns the ID_LEN characters of ID_STR, first character in the top byte. 'x' and 'y' return 0x0D only.
- R6: 'c' issues 0x40, addr[15:8], addr[7:0], data. 'C' issues 0x48, addr[15:8], addr[7:0], data and then increments the address. The data byte is inverted when the device code is 0x40. Both reply 0x0D.
- R7: After 'c' or 'C', a short wait (wait_long=0) is requested unless the device code is 0x40 or 0x41, in which case there is no wait. 'D' always requests a short wait. 'm', 'e' and 'l' request a long wait (wait_long=1). The reply comes after wait_done.
- R8: 'R' issues 0x28, ah, al, 0x00 and then 0x20, ah, al, 0x00. It returns the byte read in the fourth slot of each instruction, in that order, with no 0x0D. The address then increments, with carry into the high byte.
- R9: 'd' issues 0xA0, ah, al, 0x00 and returns the fourth byte read. 'D' issues 0xC0, ah, al, data and replies 0x0D. 'm' issues 0x4C, ah, al, 0x00 and replies 0x0D.
- R10: 'e' issues 0xAC, 0x80, 0x04, 0x00. 'l' issues 0xAC, (arg AND 0x06) OR 0xE0, 0x00, 0x00. Both reply 0x0D.
- R11: 's' issues three instructions 0x30, 0x00, k, 0x00 for k = 2, 1, 0 and returns the three fourth-slot bytes in that order.
- R12: While a request waits for its acknowledge, spi_req/spi_tx, wait_req/wait_long and tx_valid/tx_data hold steady. At most one of rx_ready, spi_req, wait_req and tx_valid is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Host byte available |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Host byte taken on a cycle with rx_valid |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Reply sink takes the byte |
| spi_req | output | 1 | Serial engine byte request |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte exchanged; spi_rx is valid this cycle |
| spi_rx | input | 8 | Byte shifted in |
| wait_req | output | 1 | Post-write wait request |
| wait_long | output | 1 | 1 selects the long wait |
| wait_done | input | 1 | Wait finished |

## Verification
The bench builds the block with SW_MAJOR=3, SW_MINOR=4, HW_MAJOR=2, HW_MINOR=9 and a seven-character identifier "TESTPGM". With these values, distinct digits and characters show up in the 'V', 'v' and 'S' replies, so swapped or fixed values are caught. The default device lists are kept. This places the inverting code 0x40 and the page-mode code 0x41 inside the supported set, and 0x99 outside it, which exercises the gate. The serial engine model returns a different byte on every transfer, so each returned read byte can be matched to the slot it came from.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

  localparam int STEP_W = 4;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARG, ST_PLAN, ST_SPI, ST_WAIT, ST_EMIT
  } st_e;

  typedef enum logic [2:0] {
    ACT_DONE, ACT_EMIT, ACT_INSTR, ACT_WAIT, ACT_INC, ACT_SKIP
  } act_e;

  typedef struct packed {
    act_e       kind;
    logic       lng;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] b3;
  } act_t;

  localparam logic [7:0] CH_ESC = 8'h1B;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_ERR = 8'h3F;

  localparam logic [7:0] K_TYPE   = 8'h54; // T
  localparam logic [7:0] K_SWID   = 8'h53; // S
  localparam logic [7:0] K_SWVER  = 8'h56; // V
  localparam logic [7:0] K_HWVER  = 8'h76; // v
  localparam logic [7:0] K_LIST   = 8'h74; // t
  localparam logic [7:0] K_PTYPE  = 8'h70; // p
  localparam logic [7:0] K_LEDON  = 8'h78; // x
  localparam logic [7:0] K_LEDOFF = 8'h79; // y
  localparam logic [7:0] K_ADDR   = 8'h41; // A
  localparam logic [7:0] K_WLO    = 8'h63; // c
  localparam logic [7:0] K_WHI    = 8'h43; // C
  localparam logic [7:0] K_WDATA  = 8'h44; // D
  localparam logic [7:0] K_RDATA  = 8'h64; // d
  localparam logic [7:0] K_RPROG  = 8'h52; // R
  localparam logic [7:0] K_PAGE   = 8'h6D; // m
  localparam logic [7:0] K_ERASE  = 8'h65; // e
  localparam logic [7:0] K_LOCK   = 8'h6C; // l
  localparam logic [7:0] K_SIG    = 8'h73; // s

  function automatic logic is_free(input logic [7:0] b);
    return (b == K_TYPE) || (b == K_SWID) || (b == K_SWVER) || (b == K_HWVER) ||
           (b == K_LIST) || (b == K_PTYPE) || (b == K_LEDON) || (b == K_LEDOFF);
  endfunction

  function automatic logic [1:0] arg_count(input logic [7:0] b);
    if (b == K_ADDR) return 2'd2;
    if ((b == K_TYPE) || (b == K_WLO) || (b == K_WHI) || (b == K_WDATA) || (b == K_LOCK))
      return 2'd1;
    return 2'd0;
  endfunction

  function automatic act_t mk(input act_e k, input logic l, input logic [7:0] a,
                              input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    act_t r;
    r.kind = k; r.lng = l; r.b0 = a; r.b1 = b; r.b2 = c; r.b3 = d;
    return r;
  endfunction

endpackage

// File: rtl/dev_match.sv
module dev_match #(
  parameter int N = 1,
  parameter logic [N*8-1:0] LIST = '0
) (
  input  logic [7:0] code,
  output logic       hit
);
  logic [N-1:0] hits;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = (code == LIST[i*8 +: 8]);
  end
  assign hit = |hits;
endmodule

// File: rtl/addr_reg.sv
module addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  assert_inc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/prog_cmd_interp.sv
module prog_cmd_interp
  import prog_cmd_pkg::*;
#(
  parameter int NUM_DEV  = 8,
  parameter logic [NUM_DEV*8-1:0] DEV_LIST = 64'h1213_2028_3848_4041,
  parameter int NUM_ADV  = 6,
  parameter int NUM_PAGE = 2,
  parameter logic [NUM_PAGE*8-1:0] PAGE_LIST = 16'h4041,
  parameter logic [7:0] INV_CODE = 8'h40,
  parameter logic [7:0] DEV_NONE = 8'h00,
  parameter int ID_LEN   = 7,
  parameter logic [ID_LEN*8-1:0] ID_STR = "HOSTPGM",
  parameter int SW_MAJOR = 1,
  parameter int SW_MINOR = 1,
  parameter int HW_MAJOR = 1,
  parameter int HW_MINOR = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       spi_req,
  output logic [7:0] spi_tx,
  input  logic       spi_ack,
  input  logic [7:0] spi_rx,
  output logic       wait_req,
  output logic       wait_long,
  input  logic       wait_done
);

  localparam logic [STEP_W-1:0] ID_STEPS  = STEP_W'(ID_LEN);
  localparam logic [STEP_W-1:0] ADV_STEPS = STEP_W'(NUM_ADV);
  localparam logic [7:0] SWMAJ_CH = 8'(8'h30 + SW_MAJOR);
  localparam logic [7:0] SWMIN_CH = 8'(8'h30 + SW_MINOR);
  localparam logic [7:0] HWMAJ_CH = 8'(8'h30 + HW_MAJOR);
  localparam logic [7:0] HWMIN_CH = 8'(8'h30 + HW_MINOR);

  st_e               state_q;
  logic [7:0]        cmd_q, arg_hi_q, arg_q, dev_q, cap_q, spi_tx_q;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        need_q, idx_q;
  logic [3:0][7:0]   ins_q;
  logic              spi_req_q, wait_req_q, wait_long_q;
  logic              dev_ok, dev_page;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        ah, al, wdata, id_ch, adv_ch;
  act_t              act;
  logic              addr_load, addr_inc, out_load;

  dev_match #(.N(NUM_DEV), .LIST(DEV_LIST)) u_gate (.code(dev_q), .hit(dev_ok));
  dev_match #(.N(NUM_PAGE), .LIST(PAGE_LIST)) u_page (.code(dev_q), .hit(dev_page));

  assign ah    = addr_q[15:8];
  assign al    = addr_q[7:0];
  assign wdata = (dev_q == INV_CODE) ? ~arg_q : arg_q;

  // Table lookups for the character and device-list replies
  always_comb begin
    id_ch  = 8'h00;
    adv_ch = 8'h00;
    for (int i = 0; i < ID_LEN; i++)
      if (step_q == STEP_W'(i)) id_ch = ID_STR[(ID_LEN-1-i)*8 +: 8];
    for (int i = 0; i < NUM_ADV; i++)
      if (step_q == STEP_W'(i)) adv_ch = DEV_LIST[(NUM_DEV-1-i)*8 +: 8];
  end

  // Per-command microprogram: one action per step
  always_comb begin
    act = mk(ACT_DONE, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    case (cmd_q)
      K_TYPE, K_ADDR, K_LEDON, K_LEDOFF:
        if (step_q == 4'd0) act = mk(ACT_EMIT, 1'b0, CH_CR, 8'h00, 8'h00, 8'h00);
      K_SWID:
        if (step_q < ID_STEPS) act = mk(ACT_EMIT, 1'b0, id_ch, 8'h00, 8'h00, 8'h00);
      K_SWVER:
        if (step_q == 4'd0)      act = mk(ACT_EMIT, 1'b0, SWMAJ_CH, 8'h00, 8'h00, 8'h00);
        else if (step_q == 4'd1) act = mk(ACT_EMIT, 1'b0, SWMIN_CH, 8'h00, 8'h00, 8'h00);
      K_HWVER:
        if (step_q == 4'd0)      act = mk(ACT_EMIT, 1'b0, HWMAJ_CH, 8'h00, 8'h00, 8'h00);
        else if (step_q == 4'd1) act = mk(ACT_EMIT, 1'b0, HWMIN_CH, 8'h00, 8'h00, 8'h00);
      K_PTYPE:
        if (step_q == 4'd0) act = mk(ACT_EMIT, 1'b0, 8'h50, 8'h00, 8'h00, 8'h00);
      K_LIST:
        if (step_q < ADV_STEPS)       act = mk(ACT_EMIT, 1'b0, adv_ch, 8'h00, 8'h00, 8'h00);
        else if (step_q == ADV_STEPS) act = mk(ACT_EMIT, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
      K_WLO, K_WHI:
        case (step_q)
          4'd0: act = mk(ACT_INSTR, 1'b0, (cmd_q == K_WHI) ? 8'h48 : 8'h40, ah, al, wdata);
          4'd1: act = mk(dev_page ? ACT_SKIP : ACT_WAIT, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
          4'd2: act = mk((cmd_q == K_WHI) ? ACT_INC : ACT_SKIP, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
          4'd3: act = mk(ACT_EMIT, 1'b0, CH_CR, 8'h00, 8'h00, 8'h00);
          default: ;
        endcase
      K_WDATA:
        case (step_q)
          4'd0: act = mk(ACT_INSTR, 1'b0, 8'hC0, ah, al, arg_q);
          4'd1: act = mk(ACT_WAIT, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
          4'd2: act = mk(ACT_EMIT, 1'b0, CH_CR, 8'h00, 8'h00, 8'h00);
          default: ;
        endcase
      K_RDATA:
        case (step_q)
          4'd0: act = mk(ACT_INSTR, 1'b0, 8'hA0, ah, al, 8'h00);
          4'd1: act = mk(ACT_EMIT, 1'b0, cap_q, 8'h00, 8'h00, 8'h00);
          default: ;
        endcase
      K_RPROG:
        case (step_q)
          4'd0: act = mk(ACT_INSTR, 1'b0, 8'h28, ah, al, 8'h00);
          4'd2: act = mk(ACT_INSTR, 1'b0, 8'h20, ah, al, 8'h00);
          4'd1, 4'd3: act = mk(ACT_EMIT, 1'b0, cap_q, 8'h00, 8'h00, 8'h00);
          4'd4: act = mk(ACT_INC, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
          default: ;
        endcase
      K_PAGE, K_ERASE, K_LOCK:
        case (step_q)
          4'd0:
            if (cmd_q == K_PAGE)       act = mk(ACT_INSTR, 1'b0, 8'h4C, ah, al, 8'h00);
            else if (cmd_q == K_ERASE) act = mk(ACT_INSTR, 1'b0, 8'hAC, 8'h80, 8'h04, 8'h00);
            else act = mk(ACT_INSTR, 1'b0, 8'hAC, (arg_q & 8'h06) | 8'hE0, 8'h00, 8'h00);
          4'd1: act = mk(ACT_WAIT, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);
          4'd2: act = mk(ACT_EMIT, 1'b0, CH_CR, 8'h00, 8'h00, 8'h00);
          default: ;
        endcase
      K_SIG:
        if (step_q < 4'd6) begin
          if (!step_q[0]) act = mk(ACT_INSTR, 1'b0, 8'h30, 8'h00, 8'd2 - {6'd0, step_q[2:1]}, 8'h00);
          else            act = mk(ACT_EMIT, 1'b0, cap_q, 8'h00, 8'h00, 8'h00);
        end
      default:
        if (step_q == 4'd0) act = mk(ACT_EMIT, 1'b0, CH_ERR, 8'h00, 8'h00, 8'h00);
    endcase
  end

  assign addr_load = (state_q == ST_ARG) && rx_valid && (need_q == 2'd1) && (cmd_q == K_ADDR);
  assign addr_inc  = (state_q == ST_PLAN) && (act.kind == ACT_INC);
  assign out_load  = (state_q == ST_PLAN) && (act.kind == ACT_EMIT);

  addr_reg #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_val({arg_hi_q, rx_data}),
    .inc(addr_inc), .q(addr_q));

  out_stage #(.DW(8)) u_out (
    .clk(clk), .rst(rst), .load(out_load), .din(act.b0), .ready(tx_ready),
    .valid(tx_valid), .data(tx_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_q       <= '0;
      step_q      <= '0;
      need_q      <= '0;
      arg_hi_q    <= '0;
      arg_q       <= '0;
      dev_q       <= DEV_NONE;
      ins_q       <= '0;
      idx_q       <= '0;
      cap_q       <= '0;
      spi_req_q   <= 1'b0;
      spi_tx_q    <= '0;
      wait_req_q  <= 1'b0;
      wait_long_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:
          if (rx_valid && (rx_data != CH_ESC)) begin
            step_q <= '0;
            if (!is_free(rx_data) && !dev_ok) begin
              cmd_q   <= 8'h00;
              state_q <= ST_PLAN;
            end else begin
              cmd_q   <= rx_data;
              need_q  <= arg_count(rx_data);
              state_q <= (arg_count(rx_data) == 2'd0) ? ST_PLAN : ST_ARG;
            end
          end
        ST_ARG:
          if (rx_valid) begin
            if (need_q == 2'd2) begin
              arg_hi_q <= rx_data;
              need_q   <= 2'd1;
            end else begin
              arg_q   <= rx_data;
              need_q  <= 2'd0;
              state_q <= ST_PLAN;
              if (cmd_q == K_TYPE) dev_q <= rx_data;
            end
          end
        ST_PLAN: begin
          if (act.kind != ACT_DONE) step_q <= step_q + 1'b1;
          case (act.kind)
            ACT_DONE: state_q <= ST_IDLE;
            ACT_EMIT: state_q <= ST_EMIT;
            ACT_INSTR: begin
              spi_req_q <= 1'b1;
              spi_tx_q  <= act.b0;
              ins_q     <= {act.b3, act.b2, act.b1, act.b0};
              idx_q     <= 2'd0;
              state_q   <= ST_SPI;
            end
            ACT_WAIT: begin
              wait_req_q  <= 1'b1;
              wait_long_q <= act.lng;
              state_q     <= ST_WAIT;
            end
            default: ;
          endcase
        end
        ST_SPI:
          if (spi_ack) begin
            if (idx_q == 2'd3) begin
              cap_q     <= spi_rx;
              spi_req_q <= 1'b0;
              state_q   <= ST_PLAN;
            end else begin
              spi_tx_q <= ins_q[idx_q + 2'd1];
              idx_q    <= idx_q + 2'd1;
            end
          end
        ST_WAIT:
          if (wait_done) begin
            wait_req_q <= 1'b0;
            state_q    <= ST_PLAN;
          end
        ST_EMIT:
          if (tx_valid && tx_ready) state_q <= ST_PLAN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_ready  = (state_q == ST_IDLE) || (state_q == ST_ARG);
  assign spi_req   = spi_req_q;
  assign spi_tx    = spi_tx_q;
  assign wait_req  = wait_req_q;
  assign wait_long = wait_long_q;

  assert_spi_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !wait_done) |=> (wait_req && $stable(wait_long)));
  assert_one_owner_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_ready, spi_req, wait_req, tx_valid}));
  assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (spi_req || wait_req) |-> dev_ok);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_ready && !tx_valid && !spi_req && !wait_req));

endmodule

// File: tb/sim_prog_cmd_interp.sv
module sim_prog_cmd_interp;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, spi_req, wait_req, wait_long;
  logic [7:0] tx_data, spi_tx;
  logic tx_ready = 1'b1;
  logic spi_ack = 1'b0;
  logic [7:0] spi_rx = 8'h00;
  logic wait_done = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] tx_log [0:63];
  logic [7:0] spi_log [0:63];
  logic [7:0] spi_rxlog [0:63];
  logic       wait_log [0:15];
  int tx_n = 0, spi_n = 0, wait_n = 0, spi_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_cmd_interp #(
    .ID_LEN(7), .ID_STR("TESTPGM"),
    .SW_MAJOR(3), .SW_MINOR(4), .HW_MAJOR(2), .HW_MINOR(9)
  ) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
    .wait_req(wait_req), .wait_long(wait_long), .wait_done(wait_done));

  // Serial engine model: one byte per cycle of request, distinct return byte each time
  initial forever begin
    @(negedge clk);
    if (spi_req) begin
      spi_ack = 1'b1;
      spi_rx  = 8'hA5 ^ 8'(spi_total);
      if (spi_n < 64) begin spi_log[spi_n] = spi_tx; spi_rxlog[spi_n] = spi_rx; end
      spi_n++; spi_total++;
    end else spi_ack = 1'b0;
  end

  // Wait timer model
  initial forever begin
    @(negedge clk);
    if (wait_req && !wait_done) begin
      wait_done = 1'b1;
      if (wait_n < 16) wait_log[wait_n] = wait_long;
      wait_n++;
    end else wait_done = 1'b0;
  end

  // Reply sink log
  initial forever begin
    @(negedge clk);
    if (tx_valid && tx_ready) begin
      if (tx_n < 64) tx_log[tx_n] = tx_data;
      tx_n++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    tx_n = 0; spi_n = 0; wait_n = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    @(negedge clk);
    while (!rx_ready && n < 500) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic exp_tx(input string tag, input logic [7:0] e [$]);
    chk(tx_n == e.size(), {tag, " reply count"}, tx_n, e.size());
    foreach (e[i]) if (i < tx_n) chk(tx_log[i] == e[i], tag, tx_log[i], e[i]);
  endtask

  task automatic exp_spi(input string tag, input logic [7:0] e [$]);
    chk(spi_n == e.size(), {tag, " spi count"}, spi_n, e.size());
    foreach (e[i]) if (i < spi_n) chk(spi_log[i] == e[i], tag, spi_log[i], e[i]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(spi_req == 1'b0, "R1 spi_req", spi_req, 0);
    chk(wait_req == 1'b0, "R1 wait_req", wait_req, 0);
    clear_logs(); send(8'h41); settle();  // 'A' with no device: refused, args unread
    exp_tx("R1 R4 gated A", '{8'h3F});
    chk(spi_n == 0, "R4 no spi when refused", spi_n, 0);
    clear_logs(); send(8'h78); settle();  // next byte decoded as command
    exp_tx("R4 x after refusal", '{8'h0D});
  endtask

  task automatic t_esc();
    clear_logs(); send(8'h1B); send(8'h1B); settle();
    chk(tx_n == 0, "R2 esc silent", tx_n, 0);
    send(8'h70); settle();
    exp_tx("R2 R5 p after esc", '{8'h50});
  endtask

  task automatic t_free();
    clear_logs(); send(8'h74); settle();
    exp_tx("R5 t list", '{8'h12, 8'h13, 8'h20, 8'h28, 8'h38, 8'h48, 8'h00});
    clear_logs(); send(8'h56); settle();
    exp_tx("R5 V", '{8'h33, 8'h34});
    clear_logs(); send(8'h76); settle();
    exp_tx("R5 v", '{8'h32, 8'h39});
    clear_logs(); send(8'h53); settle();
    exp_tx("R5 S", '{8'h54, 8'h45, 8'h53, 8'h54, 8'h50, 8'h47, 8'h4D});
    clear_logs(); send(8'h79); settle();
    exp_tx("R5 y", '{8'h0D});
    chk(spi_n == 0 && wait_n == 0, "R5 y no side effect", spi_n + wait_n, 0);
  endtask

  task automatic t_write_bytes();
    clear_logs(); send(8'h54); send(8'h13); settle();
    exp_tx("R3 T", '{8'h0D});
    clear_logs(); send(8'h41); send(8'h12); send(8'h34); settle();
    exp_tx("R3 A", '{8'h0D});
    clear_logs(); send(8'h63); send(8'h5A); settle();
    exp_spi("R6 c", '{8'h40, 8'h12, 8'h34, 8'h5A});
    chk(wait_n == 1 && wait_log[0] == 1'b0, "R7 c short wait", wait_n, 1);
    exp_tx("R6 c reply", '{8'h0D});
    clear_logs(); send(8'h43); send(8'h6B); settle();
    exp_spi("R6 C", '{8'h48, 8'h12, 8'h34, 8'h6B});
    chk(wait_n == 1 && wait_log[0] == 1'b0, "R7 C short wait", wait_n, 1);
    exp_tx("R6 C reply", '{8'h0D});
    clear_logs(); send(8'h64); settle();
    exp_spi("R6 R9 d after C increment", '{8'hA0, 8'h12, 8'h35, 8'h00});
    exp_tx("R9 d data", '{spi_rxlog[3]});
  endtask

  task automatic t_page_devices();
    clear_logs(); send(8'h54); send(8'h40); send(8'h63); send(8'h0F); settle();
    exp_spi("R6 inverted data", '{8'h40, 8'h12, 8'h35, 8'hF0});
    chk(wait_n == 0, "R7 no wait dev 0x40", wait_n, 0);
    clear_logs(); send(8'h54); send(8'h41); send(8'h43); send(8'h0F); settle();
    exp_spi("R6 plain data dev 0x41", '{8'h48, 8'h12, 8'h35, 8'h0F});
    chk(wait_n == 0, "R7 no wait dev 0x41", wait_n, 0);
  endtask

  task automatic t_read_prog();
    clear_logs(); send(8'h54); send(8'h38); send(8'h41); send(8'h00); send(8'hFF); settle();
    clear_logs(); send(8'h52); settle();
    exp_spi("R8 R instrs", '{8'h28, 8'h00, 8'hFF, 8'h00, 8'h20, 8'h00, 8'hFF, 8'h00});
    exp_tx("R8 R data no CR", '{spi_rxlog[3], spi_rxlog[7]});
    clear_logs(); send(8'h64); settle();
    exp_spi("R8 address carry", '{8'hA0, 8'h01, 8'h00, 8'h00});
  endtask

  task automatic t_long_ops();
    clear_logs(); send(8'h44); send(8'h77); settle();
    exp_spi("R9 D", '{8'hC0, 8'h01, 8'h00, 8'h77});
    chk(wait_n == 1 && wait_log[0] == 1'b0, "R7 D short wait", wait_n, 1);
    exp_tx("R9 D reply", '{8'h0D});
    clear_logs(); send(8'h6D); settle();
    exp_spi("R9 m", '{8'h4C, 8'h01, 8'h00, 8'h00});
    chk(wait_n == 1 && wait_log[0] == 1'b1, "R7 m long wait", wait_n, 1);
    exp_tx("R9 m reply", '{8'h0D});
    clear_logs(); send(8'h65); settle();
    exp_spi("R10 e", '{8'hAC, 8'h80, 8'h04, 8'h00});
    chk(wait_n == 1 && wait_log[0] == 1'b1, "R7 e long wait", wait_n, 1);
    clear_logs(); send(8'h6C); send(8'h1F); settle();
    exp_spi("R10 l", '{8'hAC, 8'hE6, 8'h00, 8'h00});
    chk(wait_n == 1 && wait_log[0] == 1'b1, "R7 l long wait", wait_n, 1);
    exp_tx("R10 l reply", '{8'h0D});
  endtask

  task automatic t_signature();
    clear_logs(); send(8'h73); settle();
    exp_spi("R11 s", '{8'h30, 8'h00, 8'h02, 8'h00, 8'h30, 8'h00, 8'h01, 8'h00,
                      8'h30, 8'h00, 8'h00, 8'h00});
    exp_tx("R11 s data", '{spi_rxlog[3], spi_rxlog[7], spi_rxlog[11]});
  endtask

  task automatic t_errors();
    clear_logs(); send(8'h51); settle();
    exp_tx("R4 unknown letter", '{8'h3F});
    clear_logs(); send(8'h54); send(8'h99); send(8'h65); settle();
    exp_tx("R4 unsupported device", '{8'h0D, 8'h3F});
    chk(spi_n == 0, "R4 no spi for bad device", spi_n, 0);
    clear_logs(); send(8'h70); settle();
    exp_tx("R4 p with bad device", '{8'h50});
  endtask

  task automatic t_stall();
    @(posedge clk); #1 tx_ready = 1'b0;
    clear_logs(); send(8'h56);
    repeat (6) @(negedge clk);
    chk(tx_valid == 1'b1, "R12 held valid", tx_valid, 1);
    chk(tx_data == 8'h33, "R12 held data", tx_data, 8'h33);
    chk(rx_ready == 1'b0, "R12 no input while busy", rx_ready, 0);
    @(posedge clk); #1 tx_ready = 1'b1;
    settle();
    exp_tx("R12 after stall", '{8'h33, 8'h34});
  endtask

  task automatic t_reset_mid();
    send(8'h54); send(8'h12); send(8'h41); send(8'h55); send(8'h66); settle();
    do_reset();
    clear_logs(); send(8'h64); settle();
    exp_tx("R1 device cleared", '{8'h3F});
    clear_logs(); send(8'h54); send(8'h12); send(8'h64); settle();
    exp_spi("R1 address cleared", '{8'hA0, 8'h00, 8'h00, 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_esc();
    t_free();
    t_write_bytes();
    t_page_devices();
    t_read_prog();
    t_long_ops();
    t_signature();
    t_errors();
    t_stall();
    t_reset_mid();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule